// File: doc/BRIEF.md
# Instruction Fetch Address Translation Checker

This block takes an instruction-fetch virtual address with the current privilege mode and decides whether the fetch may proceed. When it may, the block produces the physical fetch address. When it may not, it reports a fault class and a trap vector. Two sources can translate a fetch. The first is a superpage window, signalled by an input strobe. The second is the result of an external page-table lookup, made of a hit bit, a physical page number and a four-bit execute-enable mask with one bit per privilege mode. The block does not hold the lookup storage itself.

The result is registered and appears one cycle after the request. A fault that is not marked as misspeculated also updates two capture registers:
- the fault tag register, which holds the fetch address that faulted;
- the formatted-address register, which holds the fetch page-table base ORed with the virtual page number shifted left by three.

The page-table base lives in a register inside the block and is written through a write-enable port.

Top module: `ifetch_xlat`

## Requirements
- R1: After reset, rsp_valid is 0, rsp_fault is NONE (code 0), rsp_vector and rsp_paddr are 0, and tag_q, form_q and the page-table base are 0.
- R2: An address is invalid unless bits [VA_W-1:VALID_W-1] are all zeros or all ones. A fetch with an invalid address reports ACV (code 1) with vector 0x0081.
- R3: A superpage fetch (sp_hit=1) reports ACV when the mode is not kernel (mode code 0). In kernel mode it succeeds, and rsp_paddr is the low PA_W bits of the address.
- R4: A fetch that is not a superpage fetch and has pt_hit=0 reports PAGE (code 2) with vector 0x0181.
- R5: On a lookup hit, pt_xre[mode] selects the enable bit. If that bit is clear, the fetch reports ACV. If it is set, rsp_paddr is {pt_ppn, va[PAGE_SHIFT-1:0]} with fault NONE and vector 0.
- R6: The checks apply in the order invalid address, superpage mode, lookup miss, permission. Only the first failing check is reported.
- R7: A fault with req_misspec=0 loads tag_q with the fetch address and loads form_q with base | (va >> PAGE_SHIFT) << 3. Both are visible in the same cycle as the response.
- R8: A fault with req_misspec=1 still reports its class and vector, and leaves tag_q and form_q unchanged.
- R9: A fetch without a fault leaves tag_q and form_q unchanged. A faulting fetch reports rsp_paddr = 0.
- R10: rsp_valid is high exactly one cycle after each cycle with req_valid=1. When rsp_valid is low, rsp_fault is NONE.
- R11: base_we=1 loads base_wdata into the page-table base. Faults captured afterwards use the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fetch request present |
| req_va | input | VA_W | Fetch virtual address |
| req_mode | input | 2 | Privilege mode, 0 = kernel |
| req_misspec | input | 1 | Request is misspeculated |
| sp_hit | input | 1 | Address falls in the superpage window |
| pt_hit | input | 1 | Page-table lookup hit |
| pt_ppn | input | PA_W-PAGE_SHIFT | Physical page number from the lookup |
| pt_xre | input | 4 | Per-mode execute enable mask |
| base_we | input | 1 | Page-table base write enable |
| base_wdata | input | VA_W | Page-table base write data |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 2 | Fault class: 0 NONE, 1 ACV, 2 PAGE |
| rsp_vector | output | 16 | Trap vector, 0 when there is no fault |
| rsp_paddr | output | PA_W | Physical fetch address |
| tag_q | output | VA_W | Captured faulting fetch address |
| form_q | output | VA_W | Captured formatted page-table address |

## Verification
Random fetches mix valid and invalid addresses, all four modes, superpage and lookup paths, random enable masks and misspeculation flags. Because the inputs are random, several checks often fail in the same request, and the reported class shows whether the priority order holds. Directed cases isolate each check:
- a superpage fetch in kernel mode against one in user mode;
- a miss with an invalid address against one with a valid address;
- a hit with only the current mode's enable bit set against one with every bit but that one set.

Capture registers are compared after every response. This separates faults that are recorded from faults that are misspeculated and from successful fetches, and it shows whether a newly written base takes effect.

// File: rtl/ifetch_xlat_pkg.sv
package ifetch_xlat_pkg;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_ACV  = 2'd1,
        FLT_PAGE = 2'd2
    } flt_e;

    localparam logic [1:0]  MODE_KERNEL = 2'd0;
    localparam logic [15:0] VEC_ACV     = 16'h0081;
    localparam logic [15:0] VEC_PAGE    = 16'h0181;

    function automatic logic [15:0] vector_of(flt_e cls);
        case (cls)
            FLT_ACV:  vector_of = VEC_ACV;
            FLT_PAGE: vector_of = VEC_PAGE;
            default:  vector_of = 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/ifetch_check.sv
module ifetch_check
    import ifetch_xlat_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PA_W       = 28,
    parameter int VALID_W    = 30,
    parameter int PAGE_SHIFT = 13
) (
    input  logic [VA_W-1:0]            va,
    input  logic [1:0]                 mode,
    input  logic                       sp_hit,
    input  logic                       pt_hit,
    input  logic [PA_W-PAGE_SHIFT-1:0] pt_ppn,
    input  logic [3:0]                 pt_xre,
    output flt_e                       cls,
    output logic [PA_W-1:0]            paddr
);
    localparam int EXT_W = VA_W - VALID_W + 1;

    logic [EXT_W-1:0] ext_bits;
    logic             va_ok;
    logic             exec_ok;

    assign ext_bits = va[VA_W-1:VALID_W-1];
    assign va_ok    = (ext_bits == '0) || (ext_bits == '1);
    assign exec_ok  = pt_xre[mode];

    always_comb begin
        cls   = FLT_NONE;
        paddr = '0;
        if (!va_ok) begin
            cls = FLT_ACV;
        end else if (sp_hit) begin
            if (mode != MODE_KERNEL) cls = FLT_ACV;
            else                     paddr = va[PA_W-1:0];
        end else if (!pt_hit) begin
            cls = FLT_PAGE;
        end else if (!exec_ok) begin
            cls = FLT_ACV;
        end else begin
            paddr = {pt_ppn, va[PAGE_SHIFT-1:0]};
        end
    end

endmodule

// File: rtl/ifetch_capture.sv
module ifetch_capture #(
    parameter int VA_W       = 32,
    parameter int PAGE_SHIFT = 13
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cap_en,
    input  logic [VA_W-1:0] va,
    input  logic            base_we,
    input  logic [VA_W-1:0] base_wdata,
    output logic [VA_W-1:0] tag_q,
    output logic [VA_W-1:0] form_q
);
    logic [VA_W-1:0] base_q;
    logic [VA_W-1:0] vpn_scaled;

    assign vpn_scaled = (va >> PAGE_SHIFT) << 3;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            tag_q  <= '0;
            form_q <= '0;
        end else begin
            if (base_we) base_q <= base_wdata;
            if (cap_en) begin
                tag_q  <= va;
                form_q <= base_q | vpn_scaled;
            end
        end
    end

endmodule

// File: rtl/ifetch_xlat.sv
module ifetch_xlat
    import ifetch_xlat_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PA_W       = 28,
    parameter int VALID_W    = 30,
    parameter int PAGE_SHIFT = 13
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [VA_W-1:0]            req_va,
    input  logic [1:0]                 req_mode,
    input  logic                       req_misspec,
    input  logic                       sp_hit,
    input  logic                       pt_hit,
    input  logic [PA_W-PAGE_SHIFT-1:0] pt_ppn,
    input  logic [3:0]                 pt_xre,
    input  logic                       base_we,
    input  logic [VA_W-1:0]            base_wdata,
    output logic                       rsp_valid,
    output logic [1:0]                 rsp_fault,
    output logic [15:0]                rsp_vector,
    output logic [PA_W-1:0]            rsp_paddr,
    output logic [VA_W-1:0]            tag_q,
    output logic [VA_W-1:0]            form_q
);
    flt_e            chk_cls;
    logic [PA_W-1:0] chk_paddr;
    logic            cap_en;

    ifetch_check #(
        .VA_W(VA_W), .PA_W(PA_W), .VALID_W(VALID_W), .PAGE_SHIFT(PAGE_SHIFT)
    ) u_check (
        .va(req_va), .mode(req_mode), .sp_hit(sp_hit), .pt_hit(pt_hit),
        .pt_ppn(pt_ppn), .pt_xre(pt_xre), .cls(chk_cls), .paddr(chk_paddr)
    );

    assign cap_en = req_valid && !req_misspec && (chk_cls != FLT_NONE);

    ifetch_capture #(
        .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT)
    ) u_capture (
        .clk(clk), .rst(rst), .cap_en(cap_en), .va(req_va),
        .base_we(base_we), .base_wdata(base_wdata),
        .tag_q(tag_q), .form_q(form_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_fault  <= FLT_NONE;
            rsp_vector <= '0;
            rsp_paddr  <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_fault  <= req_valid ? chk_cls : FLT_NONE;
            rsp_vector <= req_valid ? vector_of(chk_cls) : 16'h0000;
            rsp_paddr  <= req_valid ? chk_paddr : '0;
        end
    end

endmodule

// File: rtl/ifetch_xlat_sva.sv
module ifetch_xlat_sva #(
    parameter int VA_W = 32,
    parameter int PA_W = 28
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [VA_W-1:0] req_va,
    input logic            req_misspec,
    input logic            rsp_valid,
    input logic [1:0]      rsp_fault,
    input logic [15:0]     rsp_vector,
    input logic [PA_W-1:0] rsp_paddr,
    input logic [VA_W-1:0] tag_q,
    input logic [VA_W-1:0] form_q
);
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst) req_valid |=> rsp_valid); // R10
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst) !req_valid |=> !rsp_valid); // R10
    AST_IDLE_NO_FAULT: assert property (@(posedge clk) disable iff (rst) !rsp_valid |-> rsp_fault == 2'd0); // R10
    AST_PAGE_VECTOR: assert property (@(posedge clk) disable iff (rst) rsp_fault == 2'd2 |-> rsp_vector == 16'h0181); // R4
    AST_FAULT_PADDR_ZERO: assert property (@(posedge clk) disable iff (rst) (rsp_valid && rsp_fault != 2'd0) |-> rsp_paddr == '0); // R9
    AST_OK_HOLDS_CAPTURE: assert property (@(posedge clk) disable iff (rst) (rsp_valid && rsp_fault == 2'd0) |-> ($stable(tag_q) && $stable(form_q))); // R9
    AST_MISSPEC_HOLDS: assert property (@(posedge clk) disable iff (rst) (req_valid && req_misspec) |=> ($stable(tag_q) && $stable(form_q))); // R8
    AST_TAG_LOADS_VA: assert property (@(posedge clk) disable iff (rst) (req_valid && !req_misspec) |=> (rsp_fault == 2'd0 || tag_q == $past(req_va))); // R7
endmodule

bind ifetch_xlat ifetch_xlat_sva #(.VA_W(VA_W), .PA_W(PA_W)) u_sva (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
    .req_misspec(req_misspec), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_vector(rsp_vector), .rsp_paddr(rsp_paddr), .tag_q(tag_q), .form_q(form_q)
);

// File: tb/ifetch_xlat_bench.sv
module ifetch_xlat_bench;
    localparam int VA_W = 32;
    localparam int PA_W = 28;
    localparam int VALID_W = 30;
    localparam int PAGE_SHIFT = 13;
    localparam int PPN_W = PA_W - PAGE_SHIFT;

    logic clk = 1'b0;
    logic rst;
    logic req_valid, req_misspec, sp_hit, pt_hit, base_we;
    logic [VA_W-1:0] req_va, base_wdata;
    logic [1:0] req_mode;
    logic [PPN_W-1:0] pt_ppn;
    logic [3:0] pt_xre;
    logic rsp_valid;
    logic [1:0] rsp_fault;
    logic [15:0] rsp_vector;
    logic [PA_W-1:0] rsp_paddr;
    logic [VA_W-1:0] tag_q, form_q;

    int checks = 0;
    int fails = 0;
    logic [VA_W-1:0] m_base = '0, m_tag = '0, m_form = '0;

    always #10 clk = ~clk;

    ifetch_xlat #(.VA_W(VA_W), .PA_W(PA_W), .VALID_W(VALID_W), .PAGE_SHIFT(PAGE_SHIFT)) u_ifetch_xlat (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va), .req_mode(req_mode),
        .req_misspec(req_misspec), .sp_hit(sp_hit), .pt_hit(pt_hit), .pt_ppn(pt_ppn),
        .pt_xre(pt_xre), .base_we(base_we), .base_wdata(base_wdata), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_vector(rsp_vector), .rsp_paddr(rsp_paddr),
        .tag_q(tag_q), .form_q(form_q)
    );

    function automatic bit addr_ok(logic [VA_W-1:0] va);
        return (va[VA_W-1:VALID_W-1] == '0) || (va[VA_W-1:VALID_W-1] == '1);
    endfunction

    // expected class: 0 none, 1 acv, 2 page; also names the requirement deciding it
    function automatic logic [1:0] exp_cls(logic [VA_W-1:0] va, logic [1:0] md, bit sp, bit hit,
                                           logic [3:0] xre, output string why);
        if (!addr_ok(va)) begin why = "R2"; return 2'd1; end
        if (sp) begin why = "R3"; return (md == 2'd0) ? 2'd0 : 2'd1; end
        if (!hit) begin why = "R4"; return 2'd2; end
        why = "R5";
        return xre[md] ? 2'd0 : 2'd1;
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 0; req_va = '0; req_mode = 0; req_misspec = 0; sp_hit = 0;
        pt_hit = 0; pt_ppn = '0; pt_xre = '0; base_we = 0; base_wdata = '0;
    endtask

    task automatic fetch(logic [VA_W-1:0] va, logic [1:0] md, bit mis, bit sp, bit hit,
                         logic [PPN_W-1:0] ppn, logic [3:0] xre, string tag);
        string why;
        logic [1:0] ec;
        logic [PA_W-1:0] ep;
        req_valid = 1; req_va = va; req_mode = md; req_misspec = mis;
        sp_hit = sp; pt_hit = hit; pt_ppn = ppn; pt_xre = xre;
        @(posedge clk);
        @(negedge clk);
        idle();
        ec = exp_cls(va, md, sp, hit, xre, why);
        if (tag != "") why = tag;
        if (ec != 2'd0) ep = '0;
        else if (sp) ep = va[PA_W-1:0];
        else ep = {ppn, va[PAGE_SHIFT-1:0]};
        if (ec != 2'd0 && !mis) begin
            m_tag = va;
            m_form = m_base | ((va >> PAGE_SHIFT) << 3);
        end
        chk("R10", "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(why, "fault class", 64'(rsp_fault), 64'(ec));
        chk(why, "vector", 64'(rsp_vector),
            (ec == 2'd1) ? 64'h0081 : (ec == 2'd2) ? 64'h0181 : 64'h0);
        chk((ec != 0) ? "R9" : why, "paddr", 64'(rsp_paddr), 64'(ep));
        chk(mis ? "R8" : ((ec != 0) ? "R7" : "R9"), "tag_q", 64'(tag_q), 64'(m_tag));
        chk(mis ? "R8" : ((ec != 0) ? "R7" : "R9"), "form_q", 64'(form_q), 64'(m_form));
    endtask

    task automatic write_base(logic [VA_W-1:0] b);
        base_we = 1; base_wdata = b;
        @(posedge clk);
        @(negedge clk);
        idle();
        m_base = b;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1", "rsp_valid", 64'(rsp_valid), 0);
        chk("R1", "rsp_fault", 64'(rsp_fault), 0);
        chk("R1", "rsp_vector", 64'(rsp_vector), 0);
        chk("R1", "rsp_paddr", 64'(rsp_paddr), 0);
        chk("R1", "tag_q", 64'(tag_q), 0);
        chk("R1", "form_q", 64'(form_q), 0);
        // R1: base is zero, so the first captured form is the scaled page number alone
        fetch(32'h0000_4000, 2'd0, 0, 0, 0, '0, 4'h0, "R4");
        chk("R1", "form from zero base", 64'(form_q), 64'h10);
        // R10 idle cycle gives no response
        @(posedge clk); @(negedge clk);
        chk("R10", "idle rsp_valid", 64'(rsp_valid), 0);
        chk("R10", "idle rsp_fault", 64'(rsp_fault), 0);
        // R11 new base used by later capture
        write_base(32'hA000_0000);
        chk("R11", "form before fault", 64'(form_q), 64'(m_form));
        fetch(32'h0123_6000, 2'd1, 0, 0, 0, '0, 4'hF, "R11");
        chk("R11", "form with new base", 64'(form_q), 64'(32'hA000_0000 | (32'h0123_6000 >> 13 << 3)));
        // R3 superpage kernel vs user
        fetch(32'h0ABC_DEF8, 2'd0, 0, 1, 0, '0, 4'h0, "R3");
        fetch(32'h0ABC_DEF8, 2'd3, 0, 1, 1, 15'h1, 4'hF, "R3");
        // R6 invalid address beats superpage and miss
        fetch(32'h8000_1000, 2'd0, 0, 1, 0, '0, 4'hF, "R6");
        fetch(32'h4000_1000, 2'd2, 0, 0, 0, '0, 4'h0, "R6");
        // R6 superpage check beats lookup miss, valid negative address
        fetch(32'hE000_2000, 2'd1, 0, 1, 0, '0, 4'h0, "R6");
        // R5 only current mode bit set, and all but current
        fetch(32'h0000_3ABC, 2'd2, 0, 0, 1, 15'h7F21, 4'b0100, "R5");
        fetch(32'h0000_3ABC, 2'd2, 0, 0, 1, 15'h7F21, 4'b1011, "R5");
        // R8 misspeculated fault leaves capture alone
        fetch(32'h0777_0000, 2'd0, 1, 0, 0, '0, 4'h0, "R8");
        for (int i = 0; i < 600; i++) begin
            logic [VA_W-1:0] va;
            va = $urandom;
            if ($urandom % 4 != 0) va[VA_W-1:VALID_W-1] = va[VALID_W-1] ? '1 : '0;
            if (i % 97 == 50) write_base($urandom);
            fetch(va, 2'($urandom % 4), ($urandom % 5) == 0, ($urandom % 4) == 0,
                  ($urandom % 10) < 7, PPN_W'($urandom), 4'($urandom), "");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule